// File: doc/BRIEF.md
# Dual-mode PWM/toggle timer

This block holds two 8-bit counters and a two-bit mode input that decides how they are used. The counters can run as two separate timers that each invert a square-wave pin. They can run as two free-running PWM channels. They can also be chained into one 16-bit count, with the low byte either inverting its own pin or acting as a PWM source. Each half has its own 8-bit prescaler, and in split mode the high half can count edges of an external input instead. Each half raises its own one-cycle interrupt pulse.

Configuration is written through a small write port. Prescaler values take effect on the next clock. Period and duty values are held in shadow registers and move into the live compare registers only at a period boundary, so a running waveform never shows a mixed period. While the enable is low, every counter is held at zero, both pins are low, and the shadow values are copied straight through.

Top module: `dual_pwm_timer`

## Requirements
- R1: While `en` is low, `out_lo`, `out_hi`, `irq_lo` and `irq_hi` are low and all counters and prescalers are held at zero. All registers clear on `rst`.
- R2: With prescale value P, a half's prescaler issues one advance every P+1 enabled clocks. The count starts on the first enabled clock. A new prescale value applies from the clock after the write.
- R3: Mode 0 (`mode`=0): when a half advances while its count equals its period N, the count clears, its pin inverts and its irq pulses for one cycle. Otherwise the count increments. The pin therefore inverts every N+1 advances.
- R4: In mode 0 with `ext_sel` high, the high half advances on each rising edge of `ext_cnt` and ignores its prescaler. A level held high gives only one advance.
- R5: Mode 1 (`mode`=1): each half counts 0 to 255 and wraps. Its pin is high while the count is below its duty value. Its irq pulses when it advances from 255.
- R6: A duty of 0 keeps the PWM pin low. A duty of 255 gives 255 high samples out of every 256 counts.
- R7: A new period or duty value written while running takes effect only at the next boundary: a match in mode 0, a wrap in mode 1, or a 16-bit match in modes 2 and 3. While disabled, it takes effect at once.
- R8: Mode 2 (`mode`=2): the halves form one 16-bit count that advances on low prescaler ticks, or on `ext_cnt` rising edges when `ext_sel` is high. When the count equals {high period, low period} at an advance, it clears, `out_hi` inverts and `irq_hi` pulses.
- R9: In mode 2, every advance at which the low byte equals the low period inverts `out_lo` and pulses `irq_lo`.
- R10: Mode 3 (`mode`=3): the 16-bit count behaves as in R8, always driven by the low prescaler. `out_lo` is high while the low byte is below the low duty. `irq_lo` pulses when the low byte advances from 255.
- R11: A write with `wr_en` high stores `wr_data` at `wr_addr`. Bit 0 selects the half (0 low, 1 high). Bits 2:1 select the field: 0 prescale, 1 period, 2 duty. Field code 3 (addresses 6 and 7) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle |
| mode | input | 2 | Configuration select, 0 to 3 |
| ext_sel | input | 1 | Count external edges instead of prescaler ticks |
| ext_cnt | input | 1 | External count input, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| out_lo | output | 1 | Low-half output pin |
| out_hi | output | 1 | High-half output pin |
| irq_lo | output | 1 | Low-half interrupt pulse |
| irq_hi | output | 1 | High-half interrupt pulse |

## Verification
The bench drives the duty extremes 0 and 255. A compare that is off by one would let a lone high sample through at duty 0 or lose one at 255. It rewrites the duty in the middle of a period, where a design without shadow registers would cut the current period's high time short. Toggle gaps are measured with prescale above zero and with the 16-bit match at 0x0103, which catches a reload off by one count and a carry from the low byte that lands a cycle late. The external input is held high for several cycles to expose level counting in place of edge counting, and writes to the unused addresses must leave the measured toggle gap unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W  = 8;
    localparam int ADDR_W = 3;
    localparam logic [TMR_W-1:0] CNT_TOP = {TMR_W{1'b1}};

    typedef enum logic [1:0] {
        MD_SPLIT    = 2'd0,
        MD_DUALPWM  = 2'd1,
        MD_CASCADE  = 2'd2,
        MD_CASC_PWM = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        FLD_PRE  = 2'd0,
        FLD_PER  = 2'd1,
        FLD_DUTY = 2'd2,
        FLD_NONE = 2'd3
    } tmr_field_e;

    typedef struct packed {
        logic [TMR_W-1:0] per;
        logic [TMR_W-1:0] duty;
    } cnt_cfg_t;

    typedef struct packed {
        logic [TMR_W-1:0] pre;
        cnt_cfg_t         lim;
    } half_cfg_t;

    function automatic logic pwm_high(input logic [TMR_W-1:0] cnt,
                                      input logic [TMR_W-1:0] duty);
        return cnt < duty;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] pc;

    assign tick = run && (pc == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pc <= '0;
        else if (tick)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [TMR_W-1:0]      wr_data,
    output half_cfg_t [1:0]       cfg
);
    tmr_field_e fld;
    assign fld = tmr_field_e'(wr_addr[ADDR_W-1:1]);

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[h] <= '0;
            end else if (wr_en && (wr_addr[0] == h[0])) begin
                case (fld)
                    FLD_PRE:  cfg[h].pre      <= wr_data;
                    FLD_PER:  cfg[h].lim.per  <= wr_data;
                    FLD_DUTY: cfg[h].lim.duty <= wr_data;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  tmr_mode_e mode,
    input  logic      ext_sel,
    input  logic      ext_edge,
    input  logic      tick_lo,
    input  logic      tick_hi,
    input  cnt_cfg_t  sh_lo,
    input  cnt_cfg_t  sh_hi,
    output logic      out_lo,
    output logic      out_hi,
    output logic      irq_lo,
    output logic      irq_hi
);
    logic [TMR_W-1:0] cnt_lo, cnt_hi;
    logic             tg_lo, tg_hi;
    cnt_cfg_t         act_lo, act_hi;

    logic adv_hi, adv16;
    logic lo_match, hi_match, full_match, lo_wrap, hi_wrap;

    assign adv_hi     = (mode == MD_SPLIT && ext_sel) ? ext_edge : tick_hi;
    assign adv16      = (mode == MD_CASCADE && ext_sel) ? ext_edge : tick_lo;
    assign lo_match   = (cnt_lo == act_lo.per);
    assign hi_match   = (cnt_hi == act_hi.per);
    assign full_match = lo_match && hi_match;
    assign lo_wrap    = (cnt_lo == CNT_TOP);
    assign hi_wrap    = (cnt_hi == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0; cnt_hi <= '0;
            tg_lo  <= 1'b0; tg_hi <= 1'b0;
            irq_lo <= 1'b0; irq_hi <= 1'b0;
            act_lo <= '0; act_hi <= '0;
        end else if (!en) begin
            cnt_lo <= '0; cnt_hi <= '0;
            tg_lo  <= 1'b0; tg_hi <= 1'b0;
            irq_lo <= 1'b0; irq_hi <= 1'b0;
            act_lo <= sh_lo; act_hi <= sh_hi;
        end else begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
            case (mode)
                MD_SPLIT: begin
                    if (tick_lo) begin
                        if (lo_match) begin
                            cnt_lo <= '0; tg_lo <= ~tg_lo;
                            irq_lo <= 1'b1; act_lo <= sh_lo;
                        end else begin
                            cnt_lo <= cnt_lo + 1'b1;
                        end
                    end
                    if (adv_hi) begin
                        if (hi_match) begin
                            cnt_hi <= '0; tg_hi <= ~tg_hi;
                            irq_hi <= 1'b1; act_hi <= sh_hi;
                        end else begin
                            cnt_hi <= cnt_hi + 1'b1;
                        end
                    end
                end
                MD_DUALPWM: begin
                    if (tick_lo) begin
                        cnt_lo <= cnt_lo + 1'b1;
                        if (lo_wrap) begin
                            irq_lo <= 1'b1; act_lo <= sh_lo;
                        end
                    end
                    if (tick_hi) begin
                        cnt_hi <= cnt_hi + 1'b1;
                        if (hi_wrap) begin
                            irq_hi <= 1'b1; act_hi <= sh_hi;
                        end
                    end
                end
                MD_CASCADE, MD_CASC_PWM: begin
                    if (adv16) begin
                        if (full_match) begin
                            cnt_lo <= '0; cnt_hi <= '0;
                            tg_hi  <= ~tg_hi; irq_hi <= 1'b1;
                            act_lo <= sh_lo; act_hi <= sh_hi;
                        end else begin
                            cnt_lo <= cnt_lo + 1'b1;
                            if (lo_wrap)
                                cnt_hi <= cnt_hi + 1'b1;
                        end
                        if (mode == MD_CASCADE) begin
                            if (lo_match) begin
                                tg_lo <= ~tg_lo; irq_lo <= 1'b1;
                            end
                        end else if (lo_wrap) begin
                            irq_lo <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    logic lo_is_pwm;
    assign lo_is_pwm = (mode == MD_DUALPWM) || (mode == MD_CASC_PWM);

    assign out_lo = en && (lo_is_pwm ? pwm_high(cnt_lo, act_lo.duty) : tg_lo);
    assign out_hi = en && ((mode == MD_DUALPWM) ? pwm_high(cnt_hi, act_hi.duty) : tg_hi);
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              ext_sel,
    input  logic              ext_cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic              out_lo,
    output logic              out_hi,
    output logic              irq_lo,
    output logic              irq_hi
);
    half_cfg_t [1:0] cfg;
    logic      [1:0] tick;
    logic            ext_q;
    logic            ext_edge;

    tmr_regbank u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    for (genvar g = 0; g < 2; g++) begin : g_pre
        tmr_prescaler #(.PW(TMR_W)) u_pre (
            .clk   (clk),
            .rst   (rst),
            .run   (en),
            .limit (cfg[g].pre),
            .tick  (tick[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_cnt;
    end
    assign ext_edge = ext_cnt && !ext_q;

    tmr_core u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode     (tmr_mode_e'(mode)),
        .ext_sel  (ext_sel),
        .ext_edge (ext_edge),
        .tick_lo  (tick[0]),
        .tick_hi  (tick[1]),
        .sh_lo    (cfg[0].lim),
        .sh_hi    (cfg[1].lim),
        .out_lo   (out_lo),
        .out_hi   (out_hi),
        .irq_lo   (irq_lo),
        .irq_hi   (irq_hi)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] mode,
    input logic       out_lo,
    input logic       out_hi,
    input logic       irq_lo,
    input logic       irq_hi,
    input logic       tick_lo,
    input logic [7:0] pre_lo
);
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!irq_lo && !irq_hi)); // R1

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_lo && $past(en) && pre_lo != 8'd0 && pre_lo == $past(pre_lo))
        |-> !$past(tick_lo)); // R2

    AST_SPLIT_TOGGLE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && mode == 2'd0 && $past(mode) == 2'd0)
        |-> ((out_lo != $past(out_lo)) == irq_lo)); // R3

    AST_WIDE_TOGGLE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && mode == 2'd2 && $past(mode) == 2'd2)
        |-> ((out_hi != $past(out_hi)) == irq_hi)); // R8
endmodule

bind dual_pwm_timer tmr_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .mode    (mode),
    .out_lo  (out_lo),
    .out_hi  (out_hi),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .tick_lo (tick[0]),
    .pre_lo  (cfg[0].pre)
);

// File: tb/sim_dual_pwm_timer.sv
module sim_dual_pwm_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       ext_sel = 1'b0;
    logic       ext_cnt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       out_lo, out_hi, irq_lo, irq_hi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_pwm_timer u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .ext_sel(ext_sel),
        .ext_cnt(ext_cnt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_lo(out_lo), .out_hi(out_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Reference model state (index 0 = low half, 1 = high half)
    logic [7:0] m_pre [2];
    logic [7:0] m_per [2];
    logic [7:0] m_duty [2];
    logic [7:0] m_pc [2];
    logic [7:0] m_cnt [2];
    logic [7:0] m_aper [2];
    logic [7:0] m_aduty [2];
    logic       m_tg [2];
    logic       m_irq [2];
    logic       m_extq;

    task automatic split_step(input int h);
        if (m_cnt[h] == m_aper[h]) begin
            m_cnt[h] = 8'd0; m_tg[h] = !m_tg[h]; m_irq[h] = 1'b1;
            m_aper[h] = m_per[h]; m_aduty[h] = m_duty[h];
        end else begin
            m_cnt[h] = m_cnt[h] + 8'd1;
        end
    endtask

    task automatic pwm_step(input int h);
        if (m_cnt[h] == 8'hFF) begin
            m_irq[h] = 1'b1; m_aper[h] = m_per[h]; m_aduty[h] = m_duty[h];
        end
        m_cnt[h] = m_cnt[h] + 8'd1;
    endtask

    task automatic wide_step();
        bit lom, full, wrap;
        lom  = (m_cnt[0] == m_aper[0]);
        full = lom && (m_cnt[1] == m_aper[1]);
        wrap = (m_cnt[0] == 8'hFF);
        if (full) begin
            m_cnt[0] = 8'd0; m_cnt[1] = 8'd0;
            m_tg[1] = !m_tg[1]; m_irq[1] = 1'b1;
            for (int h = 0; h < 2; h++) begin
                m_aper[h] = m_per[h]; m_aduty[h] = m_duty[h];
            end
        end else begin
            m_cnt[0] = m_cnt[0] + 8'd1;
            if (wrap) m_cnt[1] = m_cnt[1] + 8'd1;
        end
        if (mode == 2'd2) begin
            if (lom) begin m_tg[0] = !m_tg[0]; m_irq[0] = 1'b1; end
        end else if (wrap) begin
            m_irq[0] = 1'b1;
        end
    endtask

    always @(posedge clk) begin
        bit t0, t1, edg;
        if (rst) begin
            for (int h = 0; h < 2; h++) begin
                m_pre[h] = 0; m_per[h] = 0; m_duty[h] = 0; m_pc[h] = 0;
                m_cnt[h] = 0; m_aper[h] = 0; m_aduty[h] = 0;
                m_tg[h] = 0; m_irq[h] = 0;
            end
            m_extq = 1'b0;
        end else begin
            t0  = en && (m_pc[0] == m_pre[0]);
            t1  = en && (m_pc[1] == m_pre[1]);
            edg = ext_cnt && !m_extq;
            if (!en) begin
                for (int h = 0; h < 2; h++) begin
                    m_pc[h] = 0; m_cnt[h] = 0; m_tg[h] = 0; m_irq[h] = 0;
                    m_aper[h] = m_per[h]; m_aduty[h] = m_duty[h];
                end
            end else begin
                m_pc[0] = t0 ? 8'd0 : m_pc[0] + 8'd1;
                m_pc[1] = t1 ? 8'd0 : m_pc[1] + 8'd1;
                m_irq[0] = 0; m_irq[1] = 0;
                case (mode)
                    2'd0: begin
                        if (t0) split_step(0);
                        if (ext_sel ? edg : t1) split_step(1);
                    end
                    2'd1: begin
                        if (t0) pwm_step(0);
                        if (t1) pwm_step(1);
                    end
                    default: if ((mode == 2'd2 && ext_sel) ? edg : t0) wide_step();
                endcase
            end
            if (wr_en) begin
                case (wr_addr[2:1])
                    2'd0: m_pre[wr_addr[0]]  = wr_data;
                    2'd1: m_per[wr_addr[0]]  = wr_data;
                    2'd2: m_duty[wr_addr[0]] = wr_data;
                    default: ;
                endcase
            end
            m_extq = ext_cnt;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string mode_req();
        if (!en) return "R1";
        case (mode)
            2'd0:    return "R3";
            2'd1:    return "R5";
            2'd2:    return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic int expected_pins();
        bit e_lo, e_hi;
        e_lo = en && (((mode == 2'd1) || (mode == 2'd3)) ? (m_cnt[0] < m_aduty[0]) : m_tg[0]);
        e_hi = en && ((mode == 2'd1) ? (m_cnt[1] < m_aduty[1]) : m_tg[1]);
        return {28'd0, e_lo, e_hi, m_irq[0], m_irq[1]};
    endfunction

    // One clock; compare pins and irqs with the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        chk(mode_req(), {28'd0, out_lo, out_hi, irq_lo, irq_hi}, expected_pins());
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [1:0] md, input bit xs,
                         input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] n0, input logic [7:0] n1,
                         input logic [7:0] d0, input logic [7:0] d1);
        en = 1'b0; cyc();
        mode = md; ext_sel = xs;
        wr(3'd0, p0); wr(3'd1, p1); wr(3'd2, n0);
        wr(3'd3, n1); wr(3'd4, d0); wr(3'd5, d1);
        en = 1'b1;
    endtask

    function automatic logic pin(input bit hi);
        return hi ? out_hi : out_lo;
    endfunction

    task automatic gap(input bit hi, output int n);
        logic p;
        n = 0;
        p = pin(hi);
        for (int i = 0; i < 2000; i++) begin
            cyc();
            if (pin(hi) != p) break;
        end
        p = pin(hi);
        for (int i = 0; i < 2000; i++) begin
            cyc(); n++;
            if (pin(hi) != p) break;
        end
    endtask

    task automatic highs(input bit hi, input int len, output int h);
        h = 0;
        for (int i = 0; i < len; i++) begin
            cyc();
            if (pin(hi)) h++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd2718));
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1: idle after reset
        chk("R1", {29'd0, out_lo, out_hi, irq_lo}, 0);

        // R11 + R3: period 3, then writes to the unused addresses
        setup(2'd0, 1'b0, 8'd0, 8'd0, 8'd3, 8'd9, 8'd0, 8'd0);
        en = 1'b0;
        wr(3'd6, 8'd0); wr(3'd7, 8'd0);
        en = 1'b1;
        gap(1'b0, n); chk("R3 gap period 3 (R11 ignored addr)", n, 4);
        gap(1'b1, n); chk("R3 high half gap period 9", n, 10);

        // R2: prescale 2, period 0
        setup(2'd0, 1'b0, 8'd2, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        gap(1'b0, n); chk("R2 prescale 2 gap", n, 3);

        // R4: external edges drive the high half, period 1
        setup(2'd0, 1'b1, 8'd0, 8'd0, 8'd200, 8'd1, 8'd0, 8'd0);
        ext_cnt = 1'b1; repeat (5) cyc(); ext_cnt = 1'b0; cyc();
        chk("R4 one edge, level held", out_hi, 0);
        ext_cnt = 1'b1; cyc(); ext_cnt = 1'b0; cyc();
        chk("R4 second edge toggles", out_hi, 1);

        // R6: duty 0 and duty 255
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255);
        highs(1'b0, 512, n); chk("R6 duty 0 highs", n, 0);
        highs(1'b1, 256, n); chk("R6 duty 255 highs", n, 255);

        // R7: duty rewritten mid-period keeps current period
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd128, 8'd0);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            cyc();
            if (out_lo) n++;
            if (i == 50) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'd10; end
            if (i == 51) wr_en = 1'b0;
        end
        chk("R7 old duty holds", n, 128);
        highs(1'b0, 256, n); chk("R7 new duty at boundary", n, 10);

        // R8: 16-bit match at 0x0103
        setup(2'd2, 1'b0, 8'd0, 8'd0, 8'd3, 8'd1, 8'd0, 8'd0);
        gap(1'b1, n); chk("R8 16-bit gap", n, 260);

        // R9: low-byte toggle in mode 2
        setup(2'd2, 1'b0, 8'd0, 8'd0, 8'd1, 8'd5, 8'd0, 8'd0);
        gap(1'b0, n); chk("R9 low toggle gap", n, 256);

        // R10: low byte PWM in mode 3
        setup(2'd3, 1'b0, 8'd0, 8'd0, 8'd255, 8'd255, 8'd64, 8'd0);
        highs(1'b0, 256, n); chk("R10 low PWM highs", n, 64);

        // Random segments checked cycle by cycle against the model
        for (int s = 0; s < 40; s++) begin
            setup(2'($urandom % 4), 1'($urandom % 2), 8'($urandom % 4), 8'($urandom % 4),
                  8'($urandom), 8'($urandom % 8), 8'($urandom), 8'($urandom));
            for (int c = 0; c < 300; c++) begin
                ext_cnt = 1'($urandom % 2);
                if ($urandom % 10 == 0) begin
                    wr_en = 1'b1;
                    wr_addr = 3'($urandom % 8);
                    wr_data = (wr_addr[2:1] == 2'd0) ? 8'($urandom % 4) : 8'($urandom);
                end else begin
                    wr_en = 1'b0;
                end
                if ($urandom % 50 == 0) en = !en;
                cyc();
            end
            wr_en = 1'b0;
            en = 1'b1;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule